// File: doc/BRIEF.md
# Four-Channel Period/Duty PWM Generator

The block generates four pulse-width-modulated outputs. Each channel has an up-counter that a shared prescaler steps. The counter is compared against a period value and a duty value, both set by software. The counter runs from zero up to the period value, then clears and starts the next cycle. The output sits at its active level while the count is below the duty value and at its inactive level for the rest of the cycle. A polarity bit chooses, per channel, whether the active level is high or low.

Two neighbouring 8-bit channels can be joined into one 16-bit channel when finer resolution is needed. In that case the high channel's pin carries the joined output and the low channel's pin stays inactive. New period and duty values are held back until the current cycle ends, so changing them never produces a shortened pulse. Software reaches all registers through a plain single-cycle write / registered read bus.

Top module: `pwm_quad`

## Requirements
- R1: While enabled, each 8-bit counter goes up by one on every prescaler tick. On the tick where it equals the period value it returns to 0, so a cycle lasts period+1 ticks. The count register, read while running, never exceeds the period.
- R2: The output is active while the count is below the duty value. For 0 < duty < period, the output is active for duty*2^s of every (period+1)*2^s clocks, where s is the prescaler select.
- R3: A duty value of 0 gives a constantly inactive output. A duty value equal to or greater than the period gives a constantly active output.
- R4: Control bits [3:1] hold a prescaler select s (0..7). A counter tick then occurs once every 2^s clocks.
- R5: When control bit 0 (enable) is 0, every counter reads 0 and every output pin is at its inactive level.
- R6: Period and duty writes made while a channel is running take effect only at that channel's next wrap to 0. When the unit is disabled, they take effect at once.
- R7: Control bit 4 joins channels 0 and 1, and control bit 5 joins channels 2 and 3. The joined 16-bit counter uses {high period, low period} and {high duty, low duty}, where the high channel supplies the upper byte. The result drives the high channel's pin with the high channel's polarity, and the low channel's pin stays inactive.
- R8: Bit c of the polarity register selects active-high (1) or active-low (0) for channel c. After reset, polarity is 4'hF, control is 0 and all outputs are 0.
- R9: The register map is: 0..3 hold the period for channels 0..3, 4..7 the duty, 8..11 the read-only counts, 12 the control and 13 the polarity. Read data appears on the clock edge after the address is presented, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_out | output | 4 | PWM pins, channel 0 in bit 0 |

## Verification
The counter-range assertions assume that the join bits change only while the unit is disabled. If a pair were split while running, the low counter could sit above its own period for one cycle. The bench therefore always writes enable low before it changes the join, period or duty settings of a new test, except in the directed buffering test. That test changes only the period and duty. Random periods, duties, polarities and prescaler selects are checked by counting active cycles over a whole number of periods, so the phase of the output does not affect the result.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned N_CH   = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_PS0  = 1;
  localparam int unsigned CTL_JOIN = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(sel));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) pc <= '0;
    else            pc <= pc + 1'b1;
  end

  assign tick = en && ((pc & mask) == mask);

  p_idle_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!en |-> !tick));
  p_sel0_every_clk_r4: assert property (@(posedge clk) disable iff (rst)
    ((en && sel == '0) |-> tick));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         join_en,
  input  logic [W-1:0] per_lo,
  input  logic [W-1:0] per_hi,
  input  logic [W-1:0] duty_lo,
  input  logic [W-1:0] duty_hi,
  input  logic         pol_lo,
  input  logic         pol_hi,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         pwm_lo,
  output logic         pwm_hi
);
  localparam int unsigned JW = 2 * W;

  logic [W-1:0]  sp_lo, sp_hi, sd_lo, sd_hi;
  logic [JW-1:0] cj, pj, dj;
  logic wrap_lo, wrap_hi, wrap_j, load_lo, load_hi;
  logic act_lo, act_hi, act_j;

  assign cj = {cnt_hi, cnt_lo};
  assign pj = {sp_hi, sp_lo};
  assign dj = {sd_hi, sd_lo};

  assign wrap_lo = cnt_lo >= sp_lo;
  assign wrap_hi = cnt_hi >= sp_hi;
  assign wrap_j  = cj >= pj;

  assign load_lo = !en || (tick && (join_en ? wrap_j : wrap_lo));
  assign load_hi = !en || (tick && (join_en ? wrap_j : wrap_hi));

  assign act_lo = (sd_lo != '0) && ((sd_lo >= sp_lo) || (cnt_lo < sd_lo));
  assign act_hi = (sd_hi != '0) && ((sd_hi >= sp_hi) || (cnt_hi < sd_hi));
  assign act_j  = (dj != '0) && ((dj >= pj) || (cj < dj));

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_lo <= '0; sp_hi <= '0; sd_lo <= '0; sd_hi <= '0;
      cnt_lo <= '0; cnt_hi <= '0;
      pwm_lo <= 1'b0; pwm_hi <= 1'b0;
    end else begin
      if (load_lo) begin
        sp_lo <= per_lo;
        sd_lo <= duty_lo;
      end
      if (load_hi) begin
        sp_hi <= per_hi;
        sd_hi <= duty_hi;
      end
      if (!en) begin
        cnt_lo <= '0;
        cnt_hi <= '0;
      end else if (tick) begin
        if (join_en) begin
          {cnt_hi, cnt_lo} <= wrap_j ? '0 : cj + 1'b1;
        end else begin
          cnt_lo <= wrap_lo ? '0 : cnt_lo + 1'b1;
          cnt_hi <= wrap_hi ? '0 : cnt_hi + 1'b1;
        end
      end
      pwm_lo <= (en && !join_en && act_lo) ? pol_lo : !pol_lo;
      pwm_hi <= (en && (join_en ? act_j : act_hi)) ? pol_hi : !pol_hi;
    end
  end

  p_off_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!en |=> (cnt_lo == '0 && cnt_hi == '0)));
  p_off_level_r5: assert property (@(posedge clk) disable iff (rst)
    (!en |=> (pwm_lo == !$past(pol_lo) && pwm_hi == !$past(pol_hi))));
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    ((en && tick && !join_en && cnt_lo >= sp_lo) |=> cnt_lo == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    ((en && tick && !join_en && cnt_lo < sp_lo) |=> cnt_lo == $past(cnt_lo) + 1'b1));
  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((en && !tick) |=> ($stable(cnt_lo) && $stable(cnt_hi))));
  p_buffer_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((en && !tick) |=> ($stable(sp_lo) && $stable(sd_lo) && $stable(sp_hi) && $stable(sd_hi))));
  p_joined_low_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (join_en |=> pwm_lo == !$past(pol_lo)));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_pkg::*;
#(
  parameter int unsigned DW    = CH_W,
  parameter int unsigned SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_CH-1:0]   pwm_out
);
  localparam int unsigned N_PAIR = N_CH / 2;
  localparam int unsigned CTL_W  = CTL_JOIN + N_PAIR;

  logic [DW-1:0]    per_r  [N_CH];
  logic [DW-1:0]    duty_r [N_CH];
  logic [DW-1:0]    cnt_w  [N_CH];
  logic [CTL_W-1:0] ctrl;
  logic [N_CH-1:0]  pol;
  logic             tick;
  logic [1:0]       grp, idx;

  assign grp = bus_addr[3:2];
  assign idx = bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) begin
        per_r[i]  <= '0;
        duty_r[i] <= '0;
      end
      ctrl      <= '0;
      pol       <= '1;
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        case (grp)
          2'd0: per_r[idx]  <= bus_wdata;
          2'd1: duty_r[idx] <= bus_wdata;
          2'd3: begin
            if (idx == 2'd0) ctrl <= bus_wdata[CTL_W-1:0];
            if (idx == 2'd1) pol  <= bus_wdata[N_CH-1:0];
          end
          default: ;
        endcase
      end
      case (grp)
        2'd0: bus_rdata <= per_r[idx];
        2'd1: bus_rdata <= duty_r[idx];
        2'd2: bus_rdata <= cnt_w[idx];
        default: begin
          if (idx == 2'd0)      bus_rdata <= DW'(ctrl);
          else if (idx == 2'd1) bus_rdata <= DW'(pol);
          else                  bus_rdata <= '0;
        end
      endcase
    end
  end

  pwm_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk (clk),
    .rst (rst),
    .en  (ctrl[CTL_EN]),
    .sel (ctrl[CTL_PS0 +: SEL_W]),
    .tick(tick)
  );

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    pwm_pair #(.W(DW)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl[CTL_EN]),
      .tick   (tick),
      .join_en(ctrl[CTL_JOIN + p]),
      .per_lo (per_r[2*p]),
      .per_hi (per_r[2*p+1]),
      .duty_lo(duty_r[2*p]),
      .duty_hi(duty_r[2*p+1]),
      .pol_lo (pol[2*p]),
      .pol_hi (pol[2*p+1]),
      .cnt_lo (cnt_w[2*p]),
      .cnt_hi (cnt_w[2*p+1]),
      .pwm_lo (pwm_out[2*p]),
      .pwm_hi (pwm_out[2*p+1])
    );
  end

  p_reset_pins_r8: assert property (@(posedge clk)
    ($past(rst) |-> (pwm_out == '0 && bus_rdata == '0)));
endmodule

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pwm_out;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pwm_quad dut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  function automatic int exp_active(input int per, input int duty, input int div, input int k);
    if (duty == 0) return 0;
    if (duty >= per) return k * (per + 1) * div;
    return k * duty * div;
  endfunction

  task automatic measure(input int c, input logic lvl, input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out[c] == lvl) n++;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n, sel, div;
    int per [4];
    int duty[4];
    logic [3:0] pol;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset pins", int'(pwm_out), 0);
    rd(4'd12, v); chk("R8 ctrl reset", v, 0);
    rd(4'd13, v); chk("R8 pol reset", v, 15);
    rd(4'd14, v); chk("R9 unused addr", v, 0);

    // R5: disabled, active-low polarity -> pins high, counts 0
    wr(4'd0, 8'd5); wr(4'd4, 8'd2); wr(4'd13, 8'h00);
    repeat (4) @(negedge clk);
    chk("R5 idle level active-low", int'(pwm_out), 15);
    rd(4'd8, v); chk("R5 count held 0", v, 0);
    rd(4'd0, v); chk("R9 period readback", v, 5);

    // R1..R4, R8: random 8-bit configurations
    for (int it = 0; it < 8; it++) begin
      wr(4'd12, 8'h00);
      sel = int'($urandom_range(0, 2));
      div = 1 << sel;
      pol = 4'($urandom_range(0, 15));
      for (int c = 0; c < 4; c++) begin
        per[c]  = int'($urandom_range(1, 20));
        duty[c] = int'($urandom_range(0, per[c] + 2));
        if (it == 0 && c == 0) duty[c] = 0;
        if (it == 0 && c == 1) duty[c] = per[c];
        wr(4'(c), 8'(per[c]));
        wr(4'(4 + c), 8'(duty[c]));
      end
      wr(4'd13, {4'h0, pol});
      wr(4'd12, 8'(1 + (sel << 1)));
      repeat (5) @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        measure(c, pol[c], 3 * (per[c] + 1) * div, n);
        // R2 duty ratio, R3 extremes, R4 prescale, R8 polarity
        chk($sformatf("R2/R3/R4 ch%0d per=%0d duty=%0d s=%0d", c, per[c], duty[c], sel),
            n, exp_active(per[c], duty[c], div, 3));
      end
      rd(4'(8 + it % 4), v);
      chk("R1 count within period", int'(v <= per[it % 4]), 1);
    end

    // R3 directed: duty above period on a wide period
    wr(4'd12, 8'h00); wr(4'd13, 8'h0F);
    wr(4'd2, 8'd9); wr(4'd6, 8'd200);
    wr(4'd12, 8'h01);
    measure(2, 1'b1, 50, n); chk("R3 duty>period constant active", n, 50);

    // R6: buffered update mid-cycle
    wr(4'd12, 8'h00);
    wr(4'd0, 8'd200); wr(4'd4, 8'd100);
    wr(4'd12, 8'h01);
    wr(4'd0, 8'd4); wr(4'd4, 8'd2);
    rd(4'd8, v);
    chk("R6 old period still in force", int'(v > 4), 1);
    rd(4'd0, v); chk("R9 new period stored", v, 4);

    // R7: joined pair 0/1, period 0x0103, duty 0x0081
    wr(4'd12, 8'h00);
    wr(4'd0, 8'h03); wr(4'd1, 8'h01); wr(4'd4, 8'h81); wr(4'd5, 8'h00);
    wr(4'd13, 8'h0F);
    wr(4'd12, 8'h11);
    repeat (5) @(negedge clk);
    measure(1, 1'b1, 3 * 260, n); chk("R7 joined duty on high pin", n, 3 * 129);
    measure(0, 1'b1, 300, n);     chk("R7 low pin inactive", n, 0);
    rd(4'd9, v); chk("R7 high count byte bounded", int'(v <= 1), 1);

    // R5: disable after running
    wr(4'd12, 8'h00);
    rd(4'd8, v); chk("R5 count cleared on disable", v, 0);
    rd(4'd9, v); chk("R5 high count cleared", v, 0);
    @(negedge clk);
    chk("R5 pins inactive", int'(pwm_out), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule